// File: doc/BRIEF.md
# GPIO Configuration Register Write Guard

This block guards the configuration registers of a general-purpose I/O controller against stray software writes. It sits between a simple register bus (one address, a write strobe, write data and registered read data) and a small register file. When the guard is armed, writes that target a fixed set of protected offsets are dropped. Each dropped write raises a sticky violation flag and stores the offending byte offset in a status word that software can read.

The guard is armed and disarmed through a mode register. That register accepts a change only when the upper 24 bits of the write data carry a fixed key. A keyed write also clears the violation flag. Reads are never blocked and have no side effects. Writes that are allowed through reach the register file on the same clock edge as the strobe.

The example layout has 16 word slots at byte offsets 0x00 to 0x3C. Slots 0x00 to 0x34 are plain 32-bit storage registers, 0x38 is the mode register and 0x3C is the read-only status word. Every offset from 0x40 upward is unmapped.

Top module: `gpio_wprot_top`

## Requirements
- R1: After reset the guard is disarmed, the violation flag and source field are zero, and every storage register reads 0.
- R2: While the guard is disarmed, a write to any storage offset (0x00 to 0x34) stores the full 32-bit data on that clock edge.
- R3: While the guard is armed, a write to a protected storage offset (0x00, 0x04, 0x08, 0x0C, 0x10, 0x14, 0x20, 0x24, 0x28, 0x2C) leaves that register unchanged.
- R4: While the guard is armed, writes to the unprotected storage offsets 0x18, 0x1C, 0x30 and 0x34 store their data normally.
- R5: A blocked write sets the violation flag (status bit 0) and puts its 16-bit byte offset in status bits [23:8]. All other status bits read 0.
- R6: A further blocked write while the flag is already set replaces the source field with the newer offset, and the flag stays set.
- R7: A write to the mode register (0x38) whose bits [31:8] equal 24'h50494F sets the arm state to data bit 0 and clears the violation flag. The mode register reads back the arm state in bit 0 and zeros in all other bits.
- R8: A write to 0x38 with any other key leaves the arm state unchanged and does not clear the flag. While the guard is armed, such a write counts as a blocked write with source 0x38.
- R9: Read data appears on the cycle after the address is presented and reflects the state before any write in that same cycle. Reading, including reading the status word, changes no state.
- R10: Writes to the status offset 0x3C and to unmapped offsets (0x40 and above) change nothing and never raise a violation. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | 16 | Byte offset used for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |

## Verification
The assertions assume that the bus carries at most one access per cycle on a single address, and that the write strobe and data are stable across the sampling edge. The bench meets this by driving every input on the falling edge and issuing one operation per cycle. Because the read path is registered, the bench checks the read data one edge after each access, against a model that updates only after the old value has been captured. The stimulus sweeps every mapped offset with the guard disarmed and armed, plus chosen unmapped offsets, and applies right and wrong keys in both arm states.

// File: rtl/gpio_wprot_pkg.sv
package gpio_wprot_pkg;
  localparam int WORD_W = 32;
  localparam int KEY_W  = 24;
  localparam logic [KEY_W-1:0] WP_KEY = 24'h50494F;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_STORE,
    SEL_MODE,
    SEL_STATUS
  } sel_e;
endpackage

// File: rtl/wprot_decode.sv
module wprot_decode
  import gpio_wprot_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NREG      = 16,
  parameter logic [NREG-3:0] PROT_MASK = '1,
  localparam int IDX_W    = $clog2(NREG)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output sel_e              sel,
  output logic              prot_hit
);
  localparam int MODE_IDX = NREG - 2;
  localparam int STAT_IDX = NREG - 1;

  logic in_range;
  logic unused_lo;
  assign unused_lo = ^addr[1:0];
  assign idx = addr[IDX_W+1:2];

  generate
    if (ADDR_W > IDX_W + 2) begin : g_hi
      assign in_range = ~|addr[ADDR_W-1:IDX_W+2];
    end else begin : g_nohi
      assign in_range = 1'b1;
    end
  endgenerate

  always_comb begin
    if (!in_range)                    sel = SEL_NONE;
    else if (idx == IDX_W'(STAT_IDX)) sel = SEL_STATUS;
    else if (idx == IDX_W'(MODE_IDX)) sel = SEL_MODE;
    else                              sel = SEL_STORE;
    prot_hit = (sel == SEL_MODE) ||
               ((sel == SEL_STORE) && PROT_MASK[idx]);
  end
endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
  import gpio_wprot_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  sel_e               sel,
  input  logic               prot_hit,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [WORD_W-1:0]  wdata,
  output logic               prot_en,
  output logic               flag,
  output logic [ADDR_W-1:0]  src,
  output logic               store_we
);
  logic key_ok, mode_wr, blocked;
  logic unused_mid;
  assign unused_mid = ^wdata[7:1];

  assign key_ok  = (wdata[WORD_W-1:WORD_W-KEY_W] == WP_KEY);
  assign mode_wr = wr && (sel == SEL_MODE);
  assign blocked = wr && prot_en && prot_hit && !(mode_wr && key_ok);
  assign store_we = wr && (sel == SEL_STORE) && !blocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      prot_en <= 1'b0;
      flag    <= 1'b0;
      src     <= '0;
    end else if (mode_wr && key_ok) begin
      prot_en <= wdata[0];
      flag    <= 1'b0;
    end else if (blocked) begin
      flag <= 1'b1;
      src  <= addr;
    end
  end

  // R5
  viol_record_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && prot_en && prot_hit && sel == SEL_STORE) |=> (flag && src == $past(addr)));
  // R7
  key_write_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_wr && key_ok) |=> (!flag && prot_en == $past(wdata[0])));
  // R8
  bad_key_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_wr && !key_ok) |=> (prot_en == $past(prot_en) && (flag || !$past(flag))));
  // R9
  read_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !wr |=> ($stable(flag) && $stable(src) && $stable(prot_en)));
  // R10
  dead_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && (sel == SEL_STATUS || sel == SEL_NONE)) |=>
      ($stable(flag) && $stable(src) && $stable(prot_en)));
endmodule

// File: rtl/wprot_regfile.sv
module wprot_regfile #(
  parameter int NSTORE = 14,
  parameter int W      = 32,
  parameter int IDX_W  = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [IDX_W-1:0]           idx,
  input  logic [W-1:0]               wdata,
  output logic [NSTORE-1:0][W-1:0]   q
);
  generate
    for (genvar i = 0; i < NSTORE; i++) begin : g_word
      always_ff @(posedge clk) begin
        if (rst)                           q[i] <= '0;
        else if (we && idx == IDX_W'(i))   q[i] <= wdata;
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_wprot_top.sv
module gpio_wprot_top
  import gpio_wprot_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NREG   = 16,
  parameter logic [NREG-3:0] PROT_MASK = 14'h0F3F
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [WORD_W-1:0]  bus_wdata,
  output logic [WORD_W-1:0]  bus_rdata
);
  localparam int IDX_W  = $clog2(NREG);
  localparam int NSTORE = NREG - 2;

  logic [IDX_W-1:0]               dec_idx;
  sel_e                           dec_sel;
  logic                           dec_prot;
  logic                           prot_en, flag, store_we;
  logic [ADDR_W-1:0]              src;
  logic [NSTORE-1:0][WORD_W-1:0]  rf_q;
  logic [WORD_W-1:0]              stat_word, rd_next;

  wprot_decode #(.ADDR_W(ADDR_W), .NREG(NREG), .PROT_MASK(PROT_MASK)) u_dec (
    .addr(bus_addr), .idx(dec_idx), .sel(dec_sel), .prot_hit(dec_prot));

  wprot_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr(bus_wr), .sel(dec_sel), .prot_hit(dec_prot),
    .addr(bus_addr), .wdata(bus_wdata), .prot_en(prot_en), .flag(flag),
    .src(src), .store_we(store_we));

  wprot_regfile #(.NSTORE(NSTORE), .W(WORD_W), .IDX_W(IDX_W)) u_rf (
    .clk(clk), .rst(rst), .we(store_we), .idx(dec_idx),
    .wdata(bus_wdata), .q(rf_q));

  always_comb begin
    stat_word             = '0;
    stat_word[0]          = flag;
    stat_word[8 +: ADDR_W] = src;
    case (dec_sel)
      SEL_STORE:  rd_next = rf_q[dec_idx];
      SEL_MODE:   rd_next = {{(WORD_W-1){1'b0}}, prot_en};
      SEL_STATUS: rd_next = stat_word;
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  // R3
  blocked_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && prot_en && dec_prot) |=> $stable(rf_q));
  // R4
  open_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && dec_sel == SEL_STORE && !dec_prot) |=>
      (rf_q[$past(dec_idx)] == $past(bus_wdata)));
endmodule

// File: tb/gpio_wprot_top_test.sv
module gpio_wprot_top_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [23:0] KEY = 24'h50494F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  gpio_wprot_top uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [31:0] m_reg [14];
  logic        m_en, m_flag;
  logic [15:0] m_src;

  function automatic bit is_prot(int i);
    return (i <= 5) || (i >= 8 && i <= 11);
  endfunction

  function automatic logic [31:0] exp_rd(logic [15:0] a);
    int i;
    if (a[15:6] != 0) return 32'h0;
    i = int'(a[5:2]);
    if (i < 14)  return m_reg[i];
    if (i == 14) return {31'b0, m_en};
    return {8'h00, m_src, 7'b0, m_flag};
  endfunction

  task automatic model_wr(logic [15:0] a, logic [31:0] d);
    int i;
    if (a[15:6] != 0) return;
    i = int'(a[5:2]);
    if (i < 14) begin
      if (m_en && is_prot(i)) begin m_flag = 1'b1; m_src = a; end
      else m_reg[i] = d;
    end else if (i == 14) begin
      if (d[31:8] == KEY) begin m_en = d[0]; m_flag = 1'b0; end
      else if (m_en) begin m_flag = 1'b1; m_src = a; end
    end
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Write, then check that the same-cycle read returned the old value (R9).
  task automatic do_wr(logic [15:0] a, logic [31:0] d);
    logic [31:0] old;
    old = exp_rd(a);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    model_wr(a, d);
    @(negedge clk);
    bus_wr = 1'b0;
    check("R9 read-before-write", bus_rdata, old);
  endtask

  task automatic do_rd(logic [15:0] a, string tag);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    check(tag, bus_rdata, exp_rd(a));
  endtask

  initial begin
    repeat (CLK_PERIOD * 15000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hang expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 14; i++) m_reg[i] = '0;
    m_en = 0; m_flag = 0; m_src = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state, R10 unmapped reads
    for (int i = 0; i < 16; i++) do_rd(16'(i * 4), "R1 reset readback");
    do_rd(16'h0040, "R10 unmapped read");
    do_rd(16'h8000, "R10 unmapped read");

    // R2 disarmed: every storage slot writable
    for (int i = 0; i < 14; i++) do_wr(16'(i * 4), 32'hA500_0000 | 32'(i * 257));
    for (int i = 0; i < 14; i++) do_rd(16'(i * 4), "R2 disarmed write");

    // R10 status and unmapped writes do nothing
    do_wr(16'h003C, 32'hFFFF_FFFF);
    do_wr(16'h0040, 32'h1234_5678);
    do_wr(16'h1000, 32'h1234_5678);
    do_rd(16'h003C, "R10 status untouched");
    do_rd(16'h0040, "R10 unmapped after write");

    // R8 wrong key while disarmed
    do_wr(16'h0038, {24'h123456, 8'h01});
    do_rd(16'h0038, "R8 wrong key no arm");
    do_rd(16'h003C, "R8 wrong key no violation when disarmed");

    // R7 arm with key
    do_wr(16'h0038, {KEY, 8'h01});
    do_rd(16'h0038, "R7 armed readback");

    // R3/R4/R5/R6 armed sweep with status after every write
    for (int i = 0; i < 14; i++) begin
      do_wr(16'(i * 4), 32'h5A00_0000 | 32'(i * 4099));
      do_rd(16'h003C, is_prot(i) ? "R5 R6 violation record" : "R4 open write no violation");
    end
    for (int i = 0; i < 14; i++)
      do_rd(16'(i * 4), is_prot(i) ? "R3 protected hold" : "R4 unprotected write");

    // R9 repeated status reads do not clear the flag
    for (int k = 0; k < 3; k++) do_rd(16'h003C, "R9 status read no side effect");

    // R7 clear flag keeping armed, then R10 dead writes raise nothing
    do_wr(16'h0038, {KEY, 8'h01});
    do_rd(16'h003C, "R7 flag cleared");
    do_wr(16'h003C, 32'hFFFF_FFFF);
    do_wr(16'h2000, 32'hFFFF_FFFF);
    do_rd(16'h003C, "R10 no violation from dead writes");

    // R8 wrong key while armed: violation at 0x38, stays armed
    do_wr(16'h0038, {24'h50494E, 8'h00});
    do_rd(16'h003C, "R8 wrong key violation");
    do_rd(16'h0038, "R8 arm state kept");

    // R6 overwrite with a newer offset
    do_wr(16'h0024, 32'hDEAD_BEEF);
    do_rd(16'h003C, "R6 newest source");

    // R7 disarm, then R2 protected slots writable again
    do_wr(16'h0038, {KEY, 8'h00});
    do_rd(16'h0038, "R7 disarmed readback");
    for (int i = 0; i < 14; i++) do_wr(16'(i * 4), ~(32'h0101_0101 * 32'(i + 1)));
    for (int i = 0; i < 14; i++) do_rd(16'(i * 4), "R2 writes after disarm");
    do_rd(16'h003C, "R5 no violation when disarmed");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule